// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block gives two independently clocked ports, A and B, a short path for single control words that skips any data queue. Each direction has its own one-word mailbox. The sending port loads the mailbox with a write strobe. A new-mail flag then rises in the receiving port's clock domain. The receiving port takes the word and clears the flag with a read strobe. The clear travels back to the sender, which may then load the next word.

The two clocks may be unrelated or identical. Only a toggle bit crosses between domains in each direction, through a two-stage synchroniser. The mailbox word itself does not cross through a synchroniser. The sender holds it unchanged from the accepted write until the clear has come back. While that round trip is in progress, the sender sees a busy indication, and any further write strobe is discarded.

Top module: `mbx_pair`

## Requirements
- R1: After reset, both new-mail flags are 0, both busy indications are 0 and both mailbox read-data outputs are all zeros.
- R2: A write strobe sampled on a rising sender clock edge while the sender's busy is 0 loads the word. The sender's busy reads 1 after that edge. Busy never rises without such a write.
- R3: After an accepted write, the receiver's new-mail flag rises within 5 receiver clock cycles. While it is high, the receiver's read-data output equals the written word.
- R4: While the new-mail flag is high and no read is applied, the flag stays high and the read-data output does not change.
- R5: A read strobe sampled on a rising receiver edge while the flag is high clears the flag after that edge. The sender's busy then returns to 0 a few sender cycles later.
- R6: A write strobe applied while the sender's busy is 1 is ignored. The mailbox keeps the earlier word, busy stays 1, and the ignored word is never delivered.
- R7: A read strobe applied while the new-mail flag is 0 has no effect. The flag stays 0 and the sender's busy is unchanged.
- R8: The A-to-B and B-to-A mailboxes work independently, with arbitrary and concurrent traffic under unrelated clock periods.
- R9: Each accepted word raises the receiver's new-mail flag exactly once, and words arrive in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_wr | input | 1 | Port A write strobe into the A-to-B mailbox |
| a_wdata | input | 36 | Word written by port A |
| a_busy | output | 1 | A-to-B mailbox holds a word not yet acknowledged |
| a_rd | input | 1 | Port A read strobe for the B-to-A mailbox |
| a_rdata | output | 36 | Contents of the B-to-A mailbox |
| a_mail | output | 1 | New-mail flag of the B-to-A mailbox |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_wr | input | 1 | Port B write strobe into the B-to-A mailbox |
| b_wdata | input | 36 | Word written by port B |
| b_busy | output | 1 | B-to-A mailbox holds a word not yet acknowledged |
| b_rd | input | 1 | Port B read strobe for the A-to-B mailbox |
| b_rdata | output | 36 | Contents of the A-to-B mailbox |
| b_mail | output | 1 | New-mail flag of the A-to-B mailbox |

## Verification
Some faults make the toggle handshake lose a step. The receiver then either never raises its flag, and the sender's busy stays stuck high, or raises it twice for one word. The first shows up within a few cycles as a word that never arrives. The second shows up on the next read as a delivery with no matching expected word. A fault in the write gating would let a second word overwrite the held one. That appears at the receiver's read-data output as soon as the flag is sampled, so the ignored word turns up where the earlier word was expected.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_WIDTH_DEF = 36;
    localparam int MBX_SYNC_DEF  = 2;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_send.sv
module mbx_send #(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             ack_sync,
    output logic             req_tog,
    output logic             busy,
    output logic [WIDTH-1:0] mail_data
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             req_tog;
        logic             ack_seen;
        logic             busy;
    } send_st_t;

    send_st_t st_d, st_q;
    logic     ack_edge;
    logic     accept;

    always_comb begin
        st_d     = st_q;
        ack_edge = ack_sync ^ st_q.ack_seen;
        accept   = wr && !st_q.busy;
        if (ack_edge) begin
            st_d.ack_seen = ~st_q.ack_seen;
            st_d.busy     = 1'b0;
        end
        if (accept) begin
            st_d.data    = wdata;
            st_d.req_tog = ~st_q.req_tog;
            st_d.busy    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tog   = st_q.req_tog;
    assign busy      = st_q.busy;
    assign mail_data = st_q.data;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !busy) |=> (busy && mail_data == $past(wdata)));
    p_busy_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr) |=> !busy);
    p_drop_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> $stable(mail_data));
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv #(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             req_sync,
    input  logic [WIDTH-1:0] mail_data,
    output logic             ack_tog,
    output logic             mail
);
    typedef struct packed {
        logic req_seen;
        logic full;
        logic ack_tog;
    } recv_st_t;

    recv_st_t st_d, st_q;
    logic     req_edge;

    always_comb begin
        st_d     = st_q;
        req_edge = req_sync ^ st_q.req_seen;
        if (req_edge) begin
            st_d.req_seen = ~st_q.req_seen;
            st_d.full     = 1'b1;
        end
        if (rd && st_q.full) begin
            st_d.full    = 1'b0;
            st_d.ack_tog = ~st_q.ack_tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tog = st_q.ack_tog;
    assign mail    = st_q.full;

    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && !rd) |=> mail);
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && !rd) |=> $stable(mail_data));
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && rd) |=> !mail);
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
    parameter int WIDTH  = 36,
    parameter int STAGES = 2
) (
    input  logic             s_clk,
    input  logic             s_rst_n,
    input  logic             s_wr,
    input  logic [WIDTH-1:0] s_wdata,
    output logic             s_busy,
    input  logic             r_clk,
    input  logic             r_rst_n,
    input  logic             r_rd,
    output logic [WIDTH-1:0] r_rdata,
    output logic             r_mail
);
    logic req_tog, req_sync, ack_tog, ack_sync;

    mbx_send #(.WIDTH(WIDTH)) u_send (
        .clk(s_clk), .rst_n(s_rst_n), .wr(s_wr), .wdata(s_wdata),
        .ack_sync(ack_sync), .req_tog(req_tog), .busy(s_busy),
        .mail_data(r_rdata)
    );

    mbx_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(r_clk), .rst_n(r_rst_n), .d(req_tog), .q(req_sync)
    );

    mbx_recv #(.WIDTH(WIDTH)) u_recv (
        .clk(r_clk), .rst_n(r_rst_n), .rd(r_rd), .req_sync(req_sync),
        .mail_data(r_rdata), .ack_tog(ack_tog), .mail(r_mail)
    );

    mbx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(ack_tog), .q(ack_sync)
    );
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int WIDTH  = MBX_WIDTH_DEF,
    parameter int STAGES = MBX_SYNC_DEF
) (
    input  logic             clk_a,
    input  logic             rst_a_n,
    input  logic             a_wr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic             a_busy,
    input  logic             a_rd,
    output logic [WIDTH-1:0] a_rdata,
    output logic             a_mail,
    input  logic             clk_b,
    input  logic             rst_b_n,
    input  logic             b_wr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic             b_busy,
    input  logic             b_rd,
    output logic [WIDTH-1:0] b_rdata,
    output logic             b_mail
);
    mbx_lane #(.WIDTH(WIDTH), .STAGES(STAGES)) u_a2b (
        .s_clk(clk_a), .s_rst_n(rst_a_n), .s_wr(a_wr), .s_wdata(a_wdata),
        .s_busy(a_busy), .r_clk(clk_b), .r_rst_n(rst_b_n), .r_rd(b_rd),
        .r_rdata(b_rdata), .r_mail(b_mail)
    );

    mbx_lane #(.WIDTH(WIDTH), .STAGES(STAGES)) u_b2a (
        .s_clk(clk_b), .s_rst_n(rst_b_n), .s_wr(b_wr), .s_wdata(b_wdata),
        .s_busy(b_busy), .r_clk(clk_a), .r_rst_n(rst_a_n), .r_rd(a_rd),
        .r_rdata(a_rdata), .r_mail(a_mail)
    );
endmodule

// File: tb/mbx_pair_tb.sv
`timescale 1ns/1ps
module mbx_pair_tb;
    localparam real CLK_PERIOD   = 10.0;
    localparam real CLK_B_PERIOD = CLK_PERIOD * 1.7;
    localparam int  W            = 36;
    localparam int  N_WORDS      = 40;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic a_wr = 1'b0, b_wr = 1'b0, a_rd = 1'b0, b_rd = 1'b0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic a_busy, b_busy, a_mail, b_mail;
    logic [W-1:0] a_rdata, b_rdata;

    int checks = 0, errors = 0;
    bit mon_en = 1'b0, done = 1'b0;
    logic [W-1:0] q_ab[$], q_ba[$];

    always #(CLK_PERIOD/2.0)   clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2.0) clk_b = ~clk_b;

    mbx_pair u_dut (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_wr(a_wr), .a_wdata(a_wdata),
        .a_busy(a_busy), .a_rd(a_rd), .a_rdata(a_rdata), .a_mail(a_mail),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_wr(b_wr), .b_wdata(b_wdata),
        .b_busy(b_busy), .b_rd(b_rd), .b_rdata(b_rdata), .b_mail(b_mail)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver, port A. With try_drop set, a second write is attempted at once (R6).
    task automatic send_a(input logic [W-1:0] w, input bit try_drop);
        int guard = 0;
        @(negedge clk_a);
        while (a_busy && guard < 500) begin @(negedge clk_a); guard++; end
        check(!a_busy, "R5 busy release A", W'(a_busy), '0);
        q_ab.push_back(w);
        a_wr = 1'b1; a_wdata = w;
        @(negedge clk_a);
        a_wr = 1'b0;
        check(a_busy, "R2 busy after write A", W'(a_busy), W'(1));
        if (try_drop) begin
            a_wr = 1'b1; a_wdata = ~w;
            @(negedge clk_a);
            a_wr = 1'b0;
            check(a_busy, "R6 busy held on dropped write A", W'(a_busy), W'(1));
        end
    endtask

    task automatic send_b(input logic [W-1:0] w, input bit try_drop);
        int guard = 0;
        @(negedge clk_b);
        while (b_busy && guard < 500) begin @(negedge clk_b); guard++; end
        check(!b_busy, "R5 busy release B", W'(b_busy), '0);
        q_ba.push_back(w);
        b_wr = 1'b1; b_wdata = w;
        @(negedge clk_b);
        b_wr = 1'b0;
        check(b_busy, "R2 busy after write B", W'(b_busy), W'(1));
        if (try_drop) begin
            b_wr = 1'b1; b_wdata = ~w;
            @(negedge clk_b);
            b_wr = 1'b0;
            check(b_busy, "R6 busy held on dropped write B", W'(b_busy), W'(1));
        end
    endtask

    // Monitor, port B (A-to-B mailbox): pops one expected word per flag (R9).
    initial begin
        forever begin
            @(negedge clk_b);
            if (mon_en && b_mail) begin
                logic [W-1:0] exp;
                int dly;
                exp = (q_ab.size() > 0) ? q_ab.pop_front() : ~b_rdata;
                check(b_rdata == exp, "R9 A-to-B word order/once", b_rdata, exp);
                dly = $urandom_range(0, 3);
                for (int i = 0; i < dly; i++) @(negedge clk_b);
                check(b_mail && b_rdata == exp, "R4 A-to-B held", b_rdata, exp);
                b_rd = 1'b1;
                @(negedge clk_b);
                b_rd = 1'b0;
                check(!b_mail, "R5 B flag cleared", W'(b_mail), '0);
            end
        end
    end

    // Monitor, port A (B-to-A mailbox).
    initial begin
        forever begin
            @(negedge clk_a);
            if (mon_en && a_mail) begin
                logic [W-1:0] exp;
                int dly;
                exp = (q_ba.size() > 0) ? q_ba.pop_front() : ~a_rdata;
                check(a_rdata == exp, "R9 B-to-A word order/once", a_rdata, exp);
                dly = $urandom_range(0, 5);
                for (int i = 0; i < dly; i++) @(negedge clk_a);
                check(a_mail && a_rdata == exp, "R4 B-to-A held", a_rdata, exp);
                a_rd = 1'b1;
                @(negedge clk_a);
                a_rd = 1'b0;
                check(!a_mail, "R5 A flag cleared", W'(a_mail), '0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk_a);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        int lat;
        repeat (5) @(negedge clk_b);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        @(negedge clk_a);
        // R1 reset state
        check(!a_mail && !b_mail, "R1 flags", W'({a_mail, b_mail}), '0);
        check(!a_busy && !b_busy, "R1 busy", W'({a_busy, b_busy}), '0);
        check(a_rdata == '0, "R1 A rdata", a_rdata, '0);
        check(b_rdata == '0, "R1 B rdata", b_rdata, '0);

        // R7 read without mail
        @(negedge clk_b); b_rd = 1'b1;
        @(negedge clk_b); b_rd = 1'b0;
        @(negedge clk_a); a_rd = 1'b1;
        @(negedge clk_a); a_rd = 1'b0;
        repeat (4) @(negedge clk_b);
        check(!a_mail && !b_mail, "R7 flags stay low", W'({a_mail, b_mail}), '0);
        check(!a_busy && !b_busy, "R7 busy unchanged", W'({a_busy, b_busy}), '0);

        // R3 latency and R6 drop, monitors off
        send_a(36'hA_1234_5678, 1'b1);
        lat = 0;
        while (!b_mail && lat < 20) begin @(negedge clk_b); lat++; end
        check(lat <= 5, "R3 flag latency", W'(lat), W'(5));
        check(b_rdata == 36'hA_1234_5678, "R3/R6 data kept", b_rdata, 36'hA_1234_5678);
        repeat (3) @(negedge clk_b);
        check(b_rdata == 36'hA_1234_5678 && b_mail, "R4 stable before read",
              b_rdata, 36'hA_1234_5678);
        mon_en = 1'b1;

        // R8 concurrent traffic in both directions
        fork
            for (int i = 0; i < N_WORDS; i++)
                send_a({$urandom(), 4'(i)}, ($urandom_range(0, 3) == 0));
            for (int i = 0; i < N_WORDS; i++)
                send_b({$urandom(), 4'(i)}, ($urandom_range(0, 3) == 0));
        join

        repeat (60) @(negedge clk_b);
        check(q_ab.size() == 0, "R9 all A-to-B delivered", W'(q_ab.size()), '0);
        check(q_ba.size() == 0, "R9 all B-to-A delivered", W'(q_ba.size()), '0);
        check(!a_busy && !b_busy, "R5/R8 busy idle at end", W'({a_busy, b_busy}), '0);
        check(!a_mail && !b_mail, "R9 no extra flag", W'({a_mail, b_mail}), '0);
        finish_run();
    end
endmodule